// File: doc/BRIEF.md
# Half-Flash Converter Digital Core

This block is the digital sequencer of an 8-bit two-pass flash converter, written so that it can stand in for the converter on the device side of a system. A falling edge on the convert-start input freezes the track/hold and begins a conversion. The external comparator bank is then read twice through a 15-bit thermometer input. In the coarse pass the bank resolves the upper nibble. In the fine pass it resolves the lower nibble. The block joins the two nibbles into one code and announces completion with an active-low end-of-conversion pulse.

Power is managed through the convert-start line. If that line is still low when the end-of-conversion pulse finishes, the core goes to sleep. A later rising edge starts a timed power-up. A separate active-low power-down input forces sleep at any moment.

A host reads results through a chip-select/read pair. The read strobe also captures the analog channel address for the next conversion. The data output carries an enable that stands for a tri-state driver.

Top module: `hfadc_core`

## Requirements
- R1: The code is {coarse count, fine count}: the upper nibble is the number of set bits in `therm_in` at the last cycle of the coarse pass, and the lower nibble is that number at the last cycle of the fine pass. `eoc_n` falls COARSE_CYC+FINE_CYC clocks after the clock that samples the convert-start falling edge.
- R2: A thermometer word is clean when its set bits form one contiguous run starting at bit 0 (bit i is comparator i). A word that is not clean still yields its set-bit count, and `code_bubble` is then 1 for that result. A result from two clean words gives `code_bubble` 0.
- R3: `sample_hold` goes high on the clock that samples the falling edge and stays high for exactly HOLD_CYC clocks.
- R4: After reset `eoc_n` is 1. Once it falls it stays low for EOC_CYC clocks and then returns high, unless R5 ends it sooner.
- R5: A rising edge on `rd_n` while `eoc_n` is low returns `eoc_n` high on the next clock.
- R6: When `eoc_n` returns high, the core enters sleep (`asleep` = 1) if `cvt_start` is low at that clock, and goes idle otherwise.
- R7: In sleep, a rising edge on `cvt_start` clears `asleep` and starts a PWRUP_CYC-clock power-up. Convert-start edges that arrive during power-up or during a conversion are ignored. After power-up, conversions work normally.
- R8: `chan_sel` loads `chan_in` on every clock where `rd_n` is low and holds its value otherwise.
- R9: `dout_oe` is 1 only while both `sel_n` and `rd_n` are low. When it is 1, `dout` carries the result register.
- R10: The result register holds the last completed code until the next conversion finishes. Reads during a conversion, or after a forced power-down, return the previous code.
- R11: `pdn_n` low forces sleep on the next clock, with `eoc_n` high and `sample_hold` low. Convert-start edges are ignored while `pdn_n` is low. Releasing `pdn_n` starts power-up.
- R12: `phase_fine` is high exactly during the FINE_CYC clocks of the fine pass and low during the coarse pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cvt_start | input | 1 | Convert-start: falling edge converts, level at end decides sleep, rising edge wakes |
| sel_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| pdn_n | input | 1 | Active-low forced power-down |
| chan_in | input | CH_W | Channel address for the next conversion |
| therm_in | input | THERM_W | Comparator thermometer word |
| chan_sel | output | CH_W | Latched channel address to the multiplexer |
| sample_hold | output | 1 | 1 = hold, 0 = track |
| phase_fine | output | 1 | 1 during the fine pass |
| eoc_n | output | 1 | Active-low end-of-conversion pulse |
| asleep | output | 1 | Core is powered down |
| code_bubble | output | 1 | Last result came from a non-clean thermometer word |
| dout | output | 2*NIB_W | Result register |
| dout_oe | output | 1 | Output driver enable |

## Verification
A falling edge is seen on the clock after the negedge that drives it. Counting from that clock, `sample_hold` is high for clocks 1 to HOLD_CYC, `phase_fine` for clocks COARSE_CYC+1 to COARSE_CYC+FINE_CYC, and `eoc_n` is low from clock COARSE_CYC+FINE_CYC+1. The bench counts these windows one negedge at a time and compares the counts against those arithmetic limits. Read-related effects (`eoc_n` release, `chan_sel` load) are checked one clock after the strobe edge. The combinational output enable is checked one time step after the strobes change. All 256 nibble pairs are swept with clean codes, and chosen bubbled words are added.

// File: rtl/hfadc_core.sv
module hfadc_core #(
  parameter int CH_W       = 3,
  parameter int THERM_W    = 15,
  parameter int NIB_W      = 4,
  parameter int HOLD_CYC   = 12,
  parameter int COARSE_CYC = 20,
  parameter int FINE_CYC   = 20,
  parameter int EOC_CYC    = 8,
  parameter int PWRUP_CYC  = 100
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cvt_start,
  input  logic                 sel_n,
  input  logic                 rd_n,
  input  logic                 pdn_n,
  input  logic [CH_W-1:0]      chan_in,
  input  logic [THERM_W-1:0]   therm_in,
  output logic [CH_W-1:0]      chan_sel,
  output logic                 sample_hold,
  output logic                 phase_fine,
  output logic                 eoc_n,
  output logic                 asleep,
  output logic                 code_bubble,
  output logic [2*NIB_W-1:0]   dout,
  output logic                 dout_oe
);
  localparam int CONV_CYC = COARSE_CYC + FINE_CYC;
  localparam int MAX_A    = (CONV_CYC > EOC_CYC) ? CONV_CYC : EOC_CYC;
  localparam int MAX_CYC  = (MAX_A > PWRUP_CYC) ? MAX_A : PWRUP_CYC;
  localparam int CNT_W    = $clog2(MAX_CYC + 1);

  typedef enum logic [2:0] {ST_IDLE, ST_COARSE, ST_FINE, ST_EOC, ST_SLEEP, ST_WAKE} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic             cvt_q, rd_q, pd_q;
  logic [NIB_W-1:0] hi_nib, th_cnt;
  logic             hi_bub, th_bub;
  logic [2*NIB_W-1:0] code_q;

  wire cvt_fall = cvt_q & ~cvt_start;
  wire cvt_rise = ~cvt_q & cvt_start;
  wire rd_rise  = ~rd_q & rd_n;

  always_comb begin
    int ones;
    logic [THERM_W-1:0] run;
    ones = 0;
    for (int i = 0; i < THERM_W; i++) ones += int'(therm_in[i]);
    for (int i = 0; i < THERM_W; i++) run[i] = (i < ones);
    th_cnt = NIB_W'(ones);
    th_bub = (run != therm_in);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      cnt <= '0;
      cvt_q <= 1'b1;
      rd_q <= 1'b1;
      pd_q <= 1'b1;
      chan_sel <= '0;
      sample_hold <= 1'b0;
      eoc_n <= 1'b1;
      hi_nib <= '0;
      hi_bub <= 1'b0;
      code_q <= '0;
      code_bubble <= 1'b0;
    end else begin
      cvt_q <= cvt_start;
      rd_q <= rd_n;
      pd_q <= pdn_n;
      if (!rd_n) chan_sel <= chan_in;
      if (!pdn_n) begin
        st <= ST_SLEEP;
        cnt <= '0;
        eoc_n <= 1'b1;
        sample_hold <= 1'b0;
      end else begin
        case (st)
          ST_IDLE: if (cvt_fall) begin
            st <= ST_COARSE;
            cnt <= '0;
            sample_hold <= 1'b1;
          end
          ST_COARSE: begin
            cnt <= cnt + 1'b1;
            if (cnt == CNT_W'(HOLD_CYC - 1)) sample_hold <= 1'b0;
            if (cnt == CNT_W'(COARSE_CYC - 1)) begin
              hi_nib <= th_cnt;
              hi_bub <= th_bub;
              st <= ST_FINE;
            end
          end
          ST_FINE: begin
            cnt <= cnt + 1'b1;
            if (cnt == CNT_W'(HOLD_CYC - 1)) sample_hold <= 1'b0;
            if (cnt == CNT_W'(CONV_CYC - 1)) begin
              code_q <= {hi_nib, th_cnt};
              code_bubble <= hi_bub | th_bub;
              eoc_n <= 1'b0;
              sample_hold <= 1'b0;
              cnt <= '0;
              st <= ST_EOC;
            end
          end
          ST_EOC: begin
            cnt <= cnt + 1'b1;
            if (cnt == CNT_W'(EOC_CYC - 1) || rd_rise) begin
              eoc_n <= 1'b1;
              st <= cvt_start ? ST_IDLE : ST_SLEEP;
            end
          end
          ST_SLEEP: if ((pdn_n && !pd_q) || cvt_rise) begin
            st <= ST_WAKE;
            cnt <= '0;
          end
          ST_WAKE: begin
            cnt <= cnt + 1'b1;
            if (cnt == CNT_W'(PWRUP_CYC - 1)) st <= ST_IDLE;
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  assign asleep     = (st == ST_SLEEP);
  assign phase_fine = (st == ST_FINE);
  assign dout       = code_q;
  assign dout_oe    = ~sel_n & ~rd_n;
endmodule

// File: rtl/hfadc_core_chk.sv
module hfadc_core_chk #(
  parameter int NIB_W    = 4,
  parameter int HOLD_CYC = 12,
  parameter int EOC_CYC  = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rd_n,
  input logic               pdn_n,
  input logic               eoc_n,
  input logic               sample_hold,
  input logic               asleep,
  input logic               phase_fine,
  input logic [2*NIB_W-1:0] dout
);
  int unsigned eoc_run, hold_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eoc_run <= 0;
      hold_run <= 0;
    end else begin
      eoc_run <= eoc_n ? 0 : eoc_run + 1;
      hold_run <= sample_hold ? hold_run + 1 : 0;
    end
  end

  AST_EOC_FROM_FINE: assert property (@(posedge clk) disable iff (!rst_n) $fell(eoc_n) |-> $past(phase_fine)); // R1
  AST_HOLD_WIDTH: assert property (@(posedge clk) disable iff (!rst_n) sample_hold |-> hold_run < HOLD_CYC); // R3
  AST_EOC_WIDTH: assert property (@(posedge clk) disable iff (!rst_n) !eoc_n |-> eoc_run < EOC_CYC); // R4
  AST_EOC_RD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) (!eoc_n && rd_n && !$past(rd_n) && pdn_n) |=> eoc_n); // R5
  AST_RESULT_KEPT: assert property (@(posedge clk) disable iff (!rst_n) (eoc_n || !$past(eoc_n)) |-> $stable(dout)); // R10
  AST_PD_FORCE: assert property (@(posedge clk) disable iff (!rst_n) !pdn_n |=> asleep && eoc_n && !sample_hold); // R11
  AST_FINE_AWAKE: assert property (@(posedge clk) disable iff (!rst_n) phase_fine |-> !asleep && eoc_n); // R12
endmodule

bind hfadc_core hfadc_core_chk #(
  .NIB_W(NIB_W), .HOLD_CYC(HOLD_CYC), .EOC_CYC(EOC_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .pdn_n(pdn_n), .eoc_n(eoc_n),
  .sample_hold(sample_hold), .asleep(asleep), .phase_fine(phase_fine), .dout(dout)
);

// File: tb/sim_hfadc_core.sv
module sim_hfadc_core;
  localparam int CLK_NS = 10;
  localparam int H = 12, C = 20, F = 20, E = 8, P = 100;

  logic clk = 0, rst_n = 0, cvt_start = 1, sel_n = 1, rd_n = 1, pdn_n = 1;
  logic [2:0]  chan_in = 0;
  logic [14:0] th_c = 0, th_f = 0;
  logic [14:0] therm_in;
  logic [2:0]  chan_sel;
  logic sample_hold, phase_fine, eoc_n, asleep, code_bubble, dout_oe;
  logic [7:0] dout;
  int n_chk = 0, n_fail = 0;

  always #(CLK_NS/2) clk = ~clk;
  assign therm_in = phase_fine ? th_f : th_c;

  hfadc_core u0 (.clk(clk), .rst_n(rst_n), .cvt_start(cvt_start), .sel_n(sel_n), .rd_n(rd_n),
    .pdn_n(pdn_n), .chan_in(chan_in), .therm_in(therm_in), .chan_sel(chan_sel),
    .sample_hold(sample_hold), .phase_fine(phase_fine), .eoc_n(eoc_n), .asleep(asleep),
    .code_bubble(code_bubble), .dout(dout), .dout_oe(dout_oe));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk); @(negedge clk);
  endtask

  function automatic logic [14:0] run(input int n);
    return 15'((32'd1 << n) - 1);
  endfunction

  function automatic int ones(input logic [14:0] v);
    int s = 0;
    for (int i = 0; i < 15; i++) s += int'(v[i]);
    return s;
  endfunction

  task automatic read_code(input int exp_code, input int exp_bub, input string req);
    sel_n = 0; rd_n = 0; #1;
    chk({req, " oe"}, int'(dout_oe), 1);
    chk({req, " code"}, int'(dout), exp_code);
    chk({req, " bubble"}, int'(code_bubble), exp_bub);
    step;
    rd_n = 1; sel_n = 1; #1;
  endtask

  // mode 0 plain, 1 timing, 2 read mid-conversion, 3 early release by read
  task automatic conv(input logic [14:0] tc, input logic [14:0] tf, input bit stay_low,
                      input int mode, input int mid_exp);
    int first = -1, hold_n = 0, ph_n = 0, eoc_cnt = 0;
    th_c = tc; th_f = tf; cvt_start = 0;
    for (int n = 1; n <= C + F + E + 3; n++) begin
      step;
      if (sample_hold) hold_n++;
      if (phase_fine) ph_n++;
      if (!eoc_n) begin
        if (first < 0) first = n;
        eoc_cnt++;
      end
      if (n == 2 && !stay_low) cvt_start = 1;
      if (mode == 1 && n == 10) cvt_start = 0;
      if (mode == 1 && n == 11) cvt_start = 1;
      if (mode == 2 && n == 25) begin sel_n = 0; rd_n = 0; end
      if (mode == 2 && n == 26) begin
        chk("R10 mid-conversion read", int'(dout), mid_exp);
        sel_n = 1; rd_n = 1;
      end
      if (mode == 3 && n == C + F + 1) begin
        chk("R5 eoc low", int'(eoc_n), 0);
        rd_n = 0;
      end
      if (mode == 3 && n == C + F + 2) begin
        chk("R5 eoc held while rd low", int'(eoc_n), 0);
        rd_n = 1;
      end
      if (mode == 3 && n == C + F + 3) chk("R5 eoc released by rd rise", int'(eoc_n), 1);
    end
    if (mode == 1) begin
      chk("R1 eoc latency", first, C + F + 1);
      chk("R3 hold width", hold_n, H);
      chk("R12 fine width", ph_n, F);
      chk("R4 eoc width", eoc_cnt, E);
      chk("R7 second fall ignored", first, C + F + 1);
    end
    if (mode != 3) chk("R6 power decision", int'(asleep), int'(stay_low));
  endtask

  initial begin
    #(CLK_NS * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    step; step; step;
    rst_n = 1;
    #1;
    chk("R4 reset eoc", int'(eoc_n), 1);
    chk("R3 reset hold", int'(sample_hold), 0);
    chk("R6 reset awake", int'(asleep), 0);
    chk("R9 reset oe", int'(dout_oe), 0);
    chk("R10 reset code", int'(dout), 0);
    chk("R12 reset phase", int'(phase_fine), 0);

    // R8 channel latch
    chan_in = 5; step;
    chk("R8 held with rd high", int'(chan_sel), 0);
    rd_n = 0; step;
    chk("R8 loaded with rd low", int'(chan_sel), 5);
    rd_n = 1; chan_in = 2; step;
    chk("R8 held after rd rise", int'(chan_sel), 5);

    // R9 output enable gating
    sel_n = 0; rd_n = 1; #1; chk("R9 sel only", int'(dout_oe), 0);
    sel_n = 1; rd_n = 0; #1; chk("R9 rd only", int'(dout_oe), 0);
    sel_n = 0; rd_n = 0; #1; chk("R9 both", int'(dout_oe), 1);
    sel_n = 1; rd_n = 1; step;

    // R1 R3 R4 R7 R12 timing
    conv(run(9), run(3), 0, 1, 0);
    read_code(8'h93, 0, "R1 timed");

    // R2 bubbled words
    conv(15'b000_0000_0101_1011, run(7), 0, 0, 0);
    read_code(8'h57, 1, "R2 coarse bubble");
    conv(run(2), 15'h4001, 0, 0, 0);
    read_code(8'h22, 1, "R2 fine bubble");

    // R10 read during conversion
    conv(run(15), run(15), 0, 2, 8'h22);
    read_code(8'hFF, 0, "R10 new code");

    // R5 read rise ends eoc
    conv(run(6), run(1), 0, 3, 0);
    step;
    read_code(8'h61, 0, "R5 code");

    // R1 R2 sweep of every clean pair
    for (int hi = 0; hi < 16; hi++)
      for (int lo = 0; lo < 16; lo++) begin
        conv(run(hi), run(lo), 0, 0, 0);
        read_code(ones(run(hi)) * 16 + ones(run(lo)), 0, "R1 sweep");
      end

    // R6 sleep, R7 wake
    conv(run(1), run(1), 1, 0, 0);
    step;
    chk("R6 remains asleep", int'(asleep), 1);
    cvt_start = 1; step;
    chk("R7 wake clears asleep", int'(asleep), 0);
    begin
      int seen = 0;
      step; step; step;
      cvt_start = 0; step; cvt_start = 1;
      for (int k = 0; k < 40; k++) begin
        step;
        if (!eoc_n || sample_hold) seen++;
      end
      chk("R7 fall during power-up ignored", seen, 0);
    end
    for (int k = 0; k < P; k++) step;
    conv(run(4), run(11), 0, 0, 0);
    read_code(8'h4B, 0, "R7 after wake");

    // R11 forced power-down
    th_c = run(3); th_f = run(3);
    cvt_start = 0; step; cvt_start = 1;
    for (int k = 0; k < 14; k++) step;
    pdn_n = 0; step;
    chk("R11 asleep", int'(asleep), 1);
    chk("R11 eoc high", int'(eoc_n), 1);
    chk("R11 hold low", int'(sample_hold), 0);
    cvt_start = 0; step; cvt_start = 1; step; step;
    chk("R11 rise ignored while forced", int'(asleep), 1);
    pdn_n = 1; step;
    chk("R11 release wakes", int'(asleep), 0);
    read_code(8'h4B, 0, "R10 code kept after power-down");
    for (int k = 0; k < P + 2; k++) step;
    conv(run(12), run(5), 0, 0, 0);
    read_code(8'hC5, 0, "R11 after release");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule